// File: doc/BRIEF.md
# Paged Virtual-to-Physical Address Translator

This block turns a 16-bit virtual address into a physical address for a memory-management unit that keeps a separate set of page registers for each processor mode (kernel, supervisor, user) and for instruction and data space. The top three virtual address bits pick one of eight pages. The page's base register is scaled by 64 and added to the 13-bit offset. The selected page descriptor then decides whether the access is allowed. It is checked for access rights, for the page length (which can grow up or down) and for a physical address beyond the installed memory.

The page-register file sits outside the block. The translator drives a combinational read address (mode, space, page) into it and takes the base and descriptor words back in the same cycle. A one-cycle access strobe launches a translation. One cycle later every result appears on registered outputs:
- the physical address;
- an abort flag with its trap vector;
- a request to rewrite the status register, with the new value;
- a request to set the written or aborted flag in the descriptor that was used.

The processor owns the status register, the descriptors and trap sequencing. It applies these requests.

Top module: `mmu_xlate`

## Requirements
- R1: With translation on (status bit 0 set), the page is va[15:13] and the physical address is base × 64 + va[12:0].
- R2: With status bit 0 clear, the physical address equals the virtual address, and the access never aborts, never requests a status update and never requests a descriptor update.
- R3: When configuration bit 4 is clear the physical address is truncated to 18 bits; when it is set, 22 bits are kept.
- R4: The read port uses data-space registers only for a data access whose mode has its configuration enable set: bit 2 for mode 0, bit 1 for mode 1, bit 0 for mode 3. Mode 2 and all instruction fetches use instruction space. The read port's mode and page follow the access.
- R5: The access code is descriptor bits 2:0. A write aborts unless the code is 6. A read aborts for codes 0, 1, 3, 4 and 7. These aborts use trap vector 250 octal.
- R6: An access-code abort reports status bit 15 (not resident) for codes 0 and 4, and status bit 13 (read only) for the other codes.
- R7: The length field va[12:6] is compared with descriptor bits 14:8. With descriptor bit 3 clear the access aborts if the field is larger; with it set, the access aborts if the field is smaller.
- R8: A length abort reports status bit 14 and uses trap vector 250 octal.
- R9: On an abort, a status update is requested only if status bits 15:13 are all zero. The new value keeps the other bits, sets the error bit, places the mode in bits 6:5 and places the page in bits 3:1.
- R10: A translated physical address at or above MEM_BYTES aborts with status bit 15 and trap vector 4 octal, whether or not checking is enabled.
- R11: An aborted write requests descriptor bit 7. A non-aborted translated word write (byte flag low) to an even address requests descriptor bit 6. The request carries the mode, space and page that were read. At most one of the two is raised.
- R12: The access-code and length checks run only when status bit 9 is set or the reduced-variant input is high.
- R13: When several faults apply, the access-code fault wins over the memory-size fault, which wins over the length fault.
- R14: All results are registered. The done output pulses exactly one cycle after a strobe. After reset every flag is low and the address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | One-cycle access strobe |
| va | input | 16 | Virtual address |
| mode | input | 2 | Processor mode (0 kernel, 1 supervisor, 3 user) |
| dspace | input | 1 | High for a data access, low for an instruction fetch |
| is_write | input | 1 | High for a write |
| is_byte | input | 1 | High for a byte access |
| mmr0 | input | 16 | Current status/control register value |
| mmr3 | input | 16 | Current configuration register value |
| reduced | input | 1 | Reduced-variant mode, forces checking on |
| pr_mode | output | 2 | Page-register file read: mode |
| pr_dsp | output | 1 | Page-register file read: data-space select |
| pr_page | output | 3 | Page-register file read: page |
| pr_par | input | 16 | Base register read data |
| pr_pdr | input | 16 | Descriptor read data |
| done | output | 1 | Result valid pulse |
| abort | output | 1 | Access aborted |
| trap_vec | output | 8 | Trap vector of the abort |
| pa | output | 22 | Physical address |
| st_wr | output | 1 | Request to rewrite the status register |
| st_val | output | 16 | New status register value |
| pd_mode | output | 2 | Descriptor update: mode |
| pd_dsp | output | 1 | Descriptor update: space |
| pd_page | output | 3 | Descriptor update: page |
| pd_set_abt | output | 1 | Request to set descriptor bit 7 |
| pd_set_wr | output | 1 | Request to set descriptor bit 6 |

## Verification
The translator holds no state between accesses other than its output registers. A wrong internal decision therefore shows at the ports on the done cycle of that same access, one clock after the strobe. A wrong space select shows even earlier, on the read-port outputs during the strobe cycle. A fault decoded with the wrong priority or the wrong kind shows as the wrong trap vector or the wrong error bit in the status value. A wrong freeze decision shows as a status write request that should have been held back. The sweep covers every mode, space, direction, access code and length relation around the limit, so a single bad decode surfaces within a few hundred cycles.

// File: rtl/mmu_xlate_pkg.sv
`timescale 1ns/1ps
package mmu_xlate_pkg;

  localparam logic [7:0] VEC_ACCESS = 8'o250;
  localparam logic [7:0] VEC_NOMEM  = 8'o004;

  localparam int ST_NONRES = 15;
  localparam int ST_LENGTH = 14;
  localparam int ST_RDONLY = 13;
  localparam logic [15:0] ST_FIELD_MASK = 16'hE06E;

  localparam int DSC_DIR    = 3;
  localparam int DSC_LEN_LO = 8;

  typedef enum logic [2:0] {
    F_NONE, F_NONRES, F_RDONLY, F_LENGTH, F_NOMEM
  } fault_e;

  function automatic logic dspace_enabled(input logic [1:0] m, input logic [2:0] en);
    case (m)
      2'd0:    return en[2];
      2'd1:    return en[1];
      2'd3:    return en[0];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mmu_space_sel.sv
`timescale 1ns/1ps
module mmu_space_sel #(
  parameter int VA_W   = 16,
  parameter int PAGE_W = 3
) (
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        mode,
  input  logic              dspace,
  input  logic [2:0]        d_en,
  output logic [PAGE_W-1:0] rd_page,
  output logic              rd_dsp
);
  import mmu_xlate_pkg::*;

  assign rd_page = va[VA_W-1 -: PAGE_W];
  assign rd_dsp  = dspace & dspace_enabled(mode, d_en);
endmodule

// File: rtl/mmu_addr_gen.sv
`timescale 1ns/1ps
module mmu_addr_gen #(
  parameter int OFS_W      = 13,
  parameter int PAR_W      = 16,
  parameter int BLK_SHIFT  = 6,
  parameter int PA_W       = 22,
  parameter int PA_SHORT_W = 18
) (
  input  logic [PAR_W-1:0] par,
  input  logic [OFS_W-1:0] ofs,
  input  logic             wide_en,
  output logic [PA_W-1:0]  pa
);
  localparam int SUM_W = PAR_W + BLK_SHIFT + 1;

  logic [SUM_W-1:0] sum;
  assign sum = {1'b0, par, {BLK_SHIFT{1'b0}}} + SUM_W'(ofs);

  logic unused_sum_hi;
  assign unused_sum_hi = ^sum[SUM_W-1:PA_W];

  generate
    if (PA_W > PA_SHORT_W) begin : g_two_widths
      assign pa = wide_en ? sum[PA_W-1:0] : PA_W'(sum[PA_SHORT_W-1:0]);
    end else begin : g_one_width
      logic unused_wide;
      assign unused_wide = wide_en;
      assign pa = sum[PA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mmu_fault_check.sv
`timescale 1ns/1ps
module mmu_fault_check #(
  parameter int     LEN_W     = 7,
  parameter int     PA_W      = 22,
  parameter longint MEM_BYTES = 1048576
) (
  input  logic             chk_en,
  input  logic             is_write,
  input  logic [2:0]       acc_code,
  input  logic             grow_down,
  input  logic [LEN_W-1:0] lim,
  input  logic [LEN_W-1:0] blk,
  input  logic [PA_W-1:0]  pa,
  output mmu_xlate_pkg::fault_e fault
);
  import mmu_xlate_pkg::*;

  logic code_bad, code_nonres, len_bad, past_mem;

  always_comb begin
    if (is_write) code_bad = (acc_code != 3'd6);
    else          code_bad = (acc_code == 3'd0) || (acc_code == 3'd1) ||
                             (acc_code == 3'd3) || (acc_code == 3'd4) ||
                             (acc_code == 3'd7);
    code_nonres = (acc_code == 3'd0) || (acc_code == 3'd4);
    len_bad     = grow_down ? (blk < lim) : (blk > lim);
    past_mem    = 64'(pa) >= 64'(MEM_BYTES);

    if (chk_en && code_bad)     fault = code_nonres ? F_NONRES : F_RDONLY;
    else if (past_mem)          fault = F_NOMEM;
    else if (chk_en && len_bad) fault = F_LENGTH;
    else                        fault = F_NONE;
  end
endmodule

// File: rtl/mmu_status_merge.sv
`timescale 1ns/1ps
module mmu_status_merge #(
  parameter int PAGE_W = 3
) (
  input  logic [15:0]       mmr0,
  input  mmu_xlate_pkg::fault_e fault,
  input  logic [1:0]        mode,
  input  logic [PAGE_W-1:0] page,
  output logic              abort,
  output logic [7:0]        vec,
  output logic              st_wr,
  output logic [15:0]       st_val
);
  import mmu_xlate_pkg::*;

  logic [15:0] err_bits;
  logic        frozen;

  assign frozen = |mmr0[15:13];

  always_comb begin
    err_bits = '0;
    vec      = '0;
    abort    = 1'b1;
    case (fault)
      F_NONRES: begin err_bits[ST_NONRES] = 1'b1; vec = VEC_ACCESS; end
      F_RDONLY: begin err_bits[ST_RDONLY] = 1'b1; vec = VEC_ACCESS; end
      F_LENGTH: begin err_bits[ST_LENGTH] = 1'b1; vec = VEC_ACCESS; end
      F_NOMEM:  begin err_bits[ST_NONRES] = 1'b1; vec = VEC_NOMEM;  end
      default:  abort = 1'b0;
    endcase
  end

  assign st_wr  = abort & ~frozen;
  assign st_val = (mmr0 & ~ST_FIELD_MASK) | err_bits |
                  (16'(mode) << 5) | (16'(page) << 1);
endmodule

// File: rtl/mmu_xlate.sv
`timescale 1ns/1ps
module mmu_xlate #(
  parameter int     VA_W       = 16,
  parameter int     PAGE_W     = 3,
  parameter int     PAR_W      = 16,
  parameter int     BLK_SHIFT  = 6,
  parameter int     PA_W       = 22,
  parameter int     PA_SHORT_W = 18,
  parameter longint MEM_BYTES  = 1048576
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_stb,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        mode,
  input  logic              dspace,
  input  logic              is_write,
  input  logic              is_byte,
  input  logic [15:0]       mmr0,
  input  logic [15:0]       mmr3,
  input  logic              reduced,
  output logic [1:0]        pr_mode,
  output logic              pr_dsp,
  output logic [PAGE_W-1:0] pr_page,
  input  logic [PAR_W-1:0]  pr_par,
  input  logic [15:0]       pr_pdr,
  output logic              done,
  output logic              abort,
  output logic [7:0]        trap_vec,
  output logic [PA_W-1:0]   pa,
  output logic              st_wr,
  output logic [15:0]       st_val,
  output logic [1:0]        pd_mode,
  output logic              pd_dsp,
  output logic [PAGE_W-1:0] pd_page,
  output logic              pd_set_abt,
  output logic              pd_set_wr
);
  import mmu_xlate_pkg::*;

  localparam int OFS_W = VA_W - PAGE_W;
  localparam int LEN_W = OFS_W - BLK_SHIFT;

  logic map_on, chk_en;
  assign map_on = mmr0[0];
  assign chk_en = mmr0[9] | reduced;

  logic unused_cfg;
  assign unused_cfg = ^{mmr3[15:5], mmr3[3], pr_pdr[15], pr_pdr[7:4]};

  mmu_space_sel #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_sel (
    .va(va), .mode(mode), .dspace(dspace), .d_en(mmr3[2:0]),
    .rd_page(pr_page), .rd_dsp(pr_dsp)
  );
  assign pr_mode = mode;

  logic [PA_W-1:0] pa_x, pa_m;
  mmu_addr_gen #(.OFS_W(OFS_W), .PAR_W(PAR_W), .BLK_SHIFT(BLK_SHIFT),
                 .PA_W(PA_W), .PA_SHORT_W(PA_SHORT_W)) u_addr (
    .par(pr_par), .ofs(va[OFS_W-1:0]), .wide_en(mmr3[4]), .pa(pa_x)
  );
  assign pa_m = map_on ? pa_x : PA_W'(va);

  fault_e fault_raw, fault;
  mmu_fault_check #(.LEN_W(LEN_W), .PA_W(PA_W), .MEM_BYTES(MEM_BYTES)) u_chk (
    .chk_en(chk_en), .is_write(is_write), .acc_code(pr_pdr[2:0]),
    .grow_down(pr_pdr[DSC_DIR]), .lim(pr_pdr[DSC_LEN_LO +: LEN_W]),
    .blk(va[OFS_W-1 -: LEN_W]), .pa(pa_x), .fault(fault_raw)
  );
  assign fault = map_on ? fault_raw : F_NONE;

  logic        ab_c, stw_c;
  logic [7:0]  vec_c;
  logic [15:0] stv_c;
  mmu_status_merge #(.PAGE_W(PAGE_W)) u_st (
    .mmr0(mmr0), .fault(fault), .mode(mode), .page(pr_page),
    .abort(ab_c), .vec(vec_c), .st_wr(stw_c), .st_val(stv_c)
  );

  logic seta_c, setw_c;
  assign seta_c = ab_c & is_write;
  assign setw_c = map_on & is_write & ~is_byte & ~va[0] & ~ab_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      abort      <= 1'b0;
      trap_vec   <= '0;
      pa         <= '0;
      st_wr      <= 1'b0;
      st_val     <= '0;
      pd_mode    <= '0;
      pd_dsp     <= 1'b0;
      pd_page    <= '0;
      pd_set_abt <= 1'b0;
      pd_set_wr  <= 1'b0;
    end else begin
      done       <= acc_stb;
      abort      <= acc_stb & ab_c;
      st_wr      <= acc_stb & stw_c;
      pd_set_abt <= acc_stb & seta_c;
      pd_set_wr  <= acc_stb & setw_c;
      if (acc_stb) begin
        trap_vec <= vec_c;
        pa       <= pa_m;
        st_val   <= stv_c;
        pd_mode  <= mode;
        pd_dsp   <= pr_dsp;
        pd_page  <= pr_page;
      end
    end
  end
endmodule

// File: rtl/mmu_xlate_chk.sv
`timescale 1ns/1ps
module mmu_xlate_chk #(
  parameter int VA_W = 16,
  parameter int PA_W = 22
) (
  input logic            clk,
  input logic            rst,
  input logic            acc_stb,
  input logic [VA_W-1:0] va,
  input logic [15:0]     mmr0,
  input logic            is_write,
  input logic            reduced,
  input logic            done,
  input logic            abort,
  input logic [7:0]      trap_vec,
  input logic [PA_W-1:0] pa,
  input logic            st_wr,
  input logic            pd_set_abt,
  input logic            pd_set_wr
);
  import mmu_xlate_pkg::*;

  a_r14_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    acc_stb |=> done);

  a_r14_abort_only_when_done: assert property (@(posedge clk) disable iff (rst)
    abort |-> done);

  a_r2_map_off_identity: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(mmr0[0])) |->
      (!abort && pa == PA_W'($past(va)) && !pd_set_abt && !pd_set_wr && !st_wr));

  a_r9_frozen_status: assert property (@(posedge clk) disable iff (rst)
    (done && ($past(mmr0[15:13]) != 3'd0)) |-> !st_wr);

  a_r9_status_needs_abort: assert property (@(posedge clk) disable iff (rst)
    st_wr |-> abort);

  a_r11_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pd_set_abt, pd_set_wr}));

  a_r11_abort_flag_on_write: assert property (@(posedge clk) disable iff (rst)
    pd_set_abt |-> (abort && $past(is_write)));

  a_r5_vector_legal: assert property (@(posedge clk) disable iff (rst)
    abort |-> (trap_vec == VEC_ACCESS || trap_vec == VEC_NOMEM));

  a_r12_checks_gated: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(mmr0[9]) && !$past(reduced)) |-> (!abort || trap_vec == VEC_NOMEM));
endmodule

bind mmu_xlate mmu_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate_chk (.*);

// File: tb/mmu_xlate_test.sv
`timescale 1ns/1ps
module mmu_xlate_test;
  localparam longint MEM = 1048576;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        acc_stb = 1'b0;
  logic [15:0] va = '0;
  logic [1:0]  mode = '0;
  logic        dspace = 1'b0, is_write = 1'b0, is_byte = 1'b0, reduced = 1'b0;
  logic [15:0] mmr0 = '0, mmr3 = '0;
  logic [1:0]  pr_mode;
  logic        pr_dsp;
  logic [2:0]  pr_page;
  logic [15:0] pr_par, pr_pdr;
  logic        done, abort, st_wr, pd_dsp, pd_set_abt, pd_set_wr;
  logic [7:0]  trap_vec;
  logic [21:0] pa;
  logic [15:0] st_val;
  logic [1:0]  pd_mode;
  logic [2:0]  pd_page;

  logic [15:0] par_m [0:3][0:1][0:7];
  logic [15:0] pdr_m [0:3][0:1][0:7];
  assign pr_par = par_m[pr_mode][pr_dsp][pr_page];
  assign pr_pdr = pdr_m[pr_mode][pr_dsp][pr_page];

  mmu_xlate uut (.*);

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic [15:0] v, input int m, input bit d, input bit w,
                            input bit b, input logic [15:0] r0, input logic [15:0] r3, input bit rd);
    bit ds, on, chk_en, acb, nr, bnd, lnb, ex_ab, ex_stw, ex_seta, ex_setw;
    logic [2:0] pg, ac;
    logic [15:0] pdr;
    longint sum, ex_pa, blk, lim;
    logic [7:0] ex_vec;
    logic [15:0] ex_err, ex_stv;
    int ncause;
    string atag, stag;
    @(negedge clk);
    chk("R14", done, 0);
    pg = v[15:13];
    case (m)
      0: ds = d && r3[2];
      1: ds = d && r3[1];
      3: ds = d && r3[0];
      default: ds = 1'b0;
    endcase
    on = r0[0];
    chk_en = r0[9] || rd;
    pdr = pdr_m[m][ds][pg];
    ac = pdr[2:0];
    sum = longint'(par_m[m][ds][pg]) * 64 + longint'(v[12:0]);
    ex_pa = !on ? longint'(v) : (r3[4] ? sum % 4194304 : sum % 262144);
    acb = chk_en && (w ? (ac != 3'd6) : (ac == 0 || ac == 1 || ac == 3 || ac == 4 || ac == 7));
    nr = (ac == 0 || ac == 4);
    bnd = ex_pa >= MEM;
    blk = (v >> 6) & 127;
    lim = (pdr >> 8) & 127;
    lnb = chk_en && (pdr[3] ? (blk < lim) : (blk > lim));
    if (!on) begin acb = 0; bnd = 0; lnb = 0; end
    ncause = int'(acb) + int'(bnd) + int'(lnb);
    ex_err = 0; ex_vec = 0;
    if (acb)      begin ex_err = nr ? 16'h8000 : 16'h2000; ex_vec = 8'o250; end
    else if (bnd) begin ex_err = 16'h8000; ex_vec = 8'o004; end
    else if (lnb) begin ex_err = 16'h4000; ex_vec = 8'o250; end
    ex_ab = acb || bnd || lnb;
    ex_stw = ex_ab && (r0[15:13] == 0);
    ex_stv = (r0 & ~16'hE06E) | ex_err | (16'(m) << 5) | (16'(pg) << 1);
    ex_seta = ex_ab && w;
    ex_setw = on && w && !b && !v[0] && !ex_ab;

    va = v; mode = 2'(m); dspace = d; is_write = w; is_byte = b;
    mmr0 = r0; mmr3 = r3; reduced = rd; acc_stb = 1'b1;
    #1;
    chk("R4", pr_dsp, ds);
    chk("R4", pr_mode, m);
    chk("R4", pr_page, pg);
    @(negedge clk);
    acc_stb = 1'b0;
    chk("R14", done, 1);
    if (ncause > 1)    atag = "R13";
    else if (acb)      atag = "R5";
    else if (bnd)      atag = "R10";
    else if (lnb)      atag = "R7";
    else if (!on)      atag = "R2";
    else if (!chk_en)  atag = "R12";
    else               atag = "R1";
    chk(atag, abort, ex_ab);
    if (ex_ab) chk(atag, trap_vec, ex_vec);
    chk(!on ? "R2" : (sum != ex_pa ? "R3" : "R1"), pa, ex_pa);
    if (r0[15:13] != 0) stag = "R9";
    else if (acb)       stag = "R6";
    else if (bnd)       stag = "R10";
    else if (lnb)       stag = "R8";
    else                stag = "R9";
    chk(stag, st_wr, ex_stw);
    if (ex_stw) chk(stag, st_val, ex_stv);
    chk("R11", pd_set_abt, ex_seta);
    chk("R11", pd_set_wr, ex_setw);
    if (ex_seta || ex_setw) begin
      chk("R11", pd_mode, m);
      chk("R11", pd_dsp, ds);
      chk("R11", pd_page, pg);
    end
  endtask

  initial begin
    int iter;
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 8; p++) begin
          par_m[m][d][p] = 16'(((m * 16 + d * 8 + p) * 16'o1237 + 16'o400) & 16'hFFFF);
          pdr_m[m][d][p] = 16'o077406;
        end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R14", done, 0);
    chk("R14", abort, 0);
    chk("R14", pa, 0);
    chk("R14", st_wr, 0);
    chk("R14", {pd_set_abt, pd_set_wr}, 0);

    iter = 0;
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int w = 0; w < 2; w++)
          for (int ac = 0; ac < 8; ac++)
            for (int dir = 0; dir < 2; dir++)
              for (int j = 0; j < 5; j++) begin
                logic [2:0] pg;
                logic [6:0] blk;
                logic [15:0] v, r0, r3, dsc;
                pg = 3'((iter * 3) % 8);
                case (j)
                  0: blk = 7'd0;
                  1: blk = 7'd63;
                  2: blk = 7'd64;
                  3: blk = 7'd65;
                  default: blk = 7'd127;
                endcase
                v = {pg, blk, 6'((j * 11 + iter) % 64)};
                dsc = {1'b0, 7'd64, 4'b0000, 1'(dir), 3'(ac)};
                pdr_m[m][0][pg] = dsc;
                pdr_m[m][1][pg] = dsc;
                r3 = 16'(((iter & 1) << 4) | ((iter >> 1) & 7));
                r0 = 16'h0001 | 16'((((iter >> 3) & 1)) << 9);
                if (iter % 4 == 3) r0 = r0 | 16'o020000;
                if (iter % 9 == 5) r0 = r0 | 16'o100000;
                if (iter % 5 == 1) r0 = r0 | 16'o000224;
                run_access(v, m, d[0], w[0], (iter % 3) == 0, r0, r3, (iter % 7) == 0);
                iter++;
              end

    for (int k = 0; k < 64; k++) begin
      logic [15:0] v;
      v = 16'((k * 16'o13571 + 16'o17) & 16'hFFFF);
      pdr_m[k % 4][k % 2][v[15:13]] = 16'o000000;
      run_access(v, k % 4, k[0], k[1], k[2], 16'o001000, 16'(k & 16'h17), k[3]);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R14 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule